// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Interrupt Steering

This block receives asynchronous serial frames on a single line and assembles them into bytes. A baud tick input, running at sixteen times the bit rate, paces all sampling. After a two-flop synchronizer, the block watches for a falling edge on the line and confirms the start bit at its half-bit point. It then samples each data bit, the optional parity bit and the stop bit in the middle of its bit period. Data arrives least significant bit first. Each frame carries 7 or 8 data bits, with no parity, even parity or odd parity.

When the stop bit is sampled, the assembled byte goes to a receive buffer and a one-cycle interrupt pulse is raised. Parity and framing faults do not stop the frame: the byte is still delivered and a sticky flag records the fault. If a frame completes while the buffer still holds an unread byte, that is an overrun. The new byte is discarded and a sticky overrun flag is set. A steering input decides whether errored frames pulse the normal completion interrupt or a separate error interrupt.

Reception runs only while both the unit enable and the receive enable are high. Dropping either one mid-frame abandons the frame without any interrupt and without touching the buffer or the flags.

Top module: `uart_rx_route`

## Requirements
- R1: After reset the buffer reads 0x00, the buffer-full, overrun, parity and framing outputs are low, and neither interrupt pulses.
- R2: A frame sent while unit_en_i or rx_en_i is low raises no interrupt and leaves rx_data_o unchanged.
- R3: A low pulse on rx_i that ends before the half-bit point of the start bit is rejected: no interrupt follows.
- R4: Each bit lasts 16 baud ticks. Data is least significant bit first. data7_i=1 selects 7 data bits, which are delivered with bit 7 cleared, and data7_i=0 selects 8. The parity_i codes are 00 none, 01 even, 10 odd and 11 none.
- R5: A clean frame loads rx_data_o, sets buf_full_o and pulses done_irq_o for exactly one cycle, on the same clock edge as the buffer update.
- R6: A wrong parity bit sets par_err_o, and the byte is still loaded into the buffer.
- R7: A stop bit sampled low sets frm_err_o, and the byte is still loaded into the buffer.
- R8: An errored frame (overrun, parity or framing) pulses done_irq_o when err_route_i=0 and err_irq_o when err_route_i=1. The two interrupts never pulse together.
- R9: A frame that completes while buf_full_o is high leaves rx_data_o unchanged and sets ovr_o.
- R10: Clearing rx_en_i during a frame aborts it with no interrupt, and the buffer contents and status flags stay unchanged.
- R11: The status flags stay set until a stat_rd_i pulse clears them. A buf_rd_i pulse clears buf_full_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_en_i | input | 1 | Unit enable |
| rx_en_i | input | 1 | Receive enable |
| baud_tick_i | input | 1 | Sampling tick at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| data7_i | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| parity_i | input | 2 | Parity mode: 00/11 none, 01 even, 10 odd |
| err_route_i | input | 1 | 1 steers errored frames to err_irq_o |
| buf_rd_i | input | 1 | Buffer read strobe, clears buf_full_o |
| stat_rd_i | input | 1 | Status read strobe, clears the flags |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| done_irq_o | output | 1 | Completion interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |
| ovr_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Sticky parity error flag |
| frm_err_o | output | 1 | Sticky framing error flag |

## Verification
The hardest case to reach from the ports is the silent mid-frame abort. To show that it leaves nothing behind, the buffer and the flags must first hold values that a stray write would visibly disturb. The bench therefore first sends a frame with bad parity so that the parity flag is set, and reads the buffer so that buf_full_o is low. It then starts a second frame and drops rx_en_i after a few data bits. It confirms that no interrupt fired and that the old byte and flags remain. Finally, a complete frame shows that the receiver recovered cleanly.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ODD   = 2'b10,
    PAR_NONE3 = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_frame_t;
endpackage

// File: rtl/rx_sync_fall.sv
module rx_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= rx_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], rx_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       fall_i,
  input  logic       seven_i,
  input  par_mode_e  par_mode_i,
  output logic       done_o,
  output rx_frame_t  frame_o
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(OSR - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              acc_q, par_bad_q, frm_q;
  logic [IDX_W-1:0]  last_idx;
  logic              par_en;

  assign last_idx = seven_i ? IDX_W'(BYTE_W - 2) : IDX_W'(BYTE_W - 1);
  assign par_en   = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      acc_q <= 1'b0; par_bad_q <= 1'b0; frm_q <= 1'b0; done_o <= 1'b0;
    end else if (!active_i) begin
      state_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fall_i) begin
          state_q <= ST_START;
          cnt_q   <= '0;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == HALF) begin
            cnt_q <= '0;
            if (line_i) state_q <= ST_IDLE;  // glitch, not a start bit
            else begin
              state_q <= ST_DATA; idx_q <= '0; sh_q <= '0;
              acc_q <= 1'b0; par_bad_q <= 1'b0;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (cnt_q == FULL) begin
            cnt_q <= '0;
            sh_q  <= {line_i, sh_q[BYTE_W-1:1]};
            acc_q <= acc_q ^ line_i;
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx) state_q <= par_en ? ST_PAR : ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: if (tick_i) begin
          if (cnt_q == FULL) begin
            cnt_q     <= '0;
            par_bad_q <= acc_q ^ line_i ^ (par_mode_i == PAR_ODD);
            state_q   <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (cnt_q == FULL) begin
            cnt_q   <= '0;
            frm_q   <= ~line_i;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign frame_o.data    = seven_i ? {1'b0, sh_q[BYTE_W-1:1]} : sh_q;
  assign frame_o.par_err = par_bad_q;
  assign frame_o.frm_err = frm_q;
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              err_route_i,
  input  logic              buf_rd_i,
  input  logic              stat_rd_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic              done_irq_o,
  output logic              err_irq_o,
  output logic              ovr_o,
  output logic              par_o,
  output logic              frm_o
);
  logic ovr_now, err_now;

  assign ovr_now = done_i & full_o;
  assign err_now = ovr_now | frame_i.par_err | frame_i.frm_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0; full_o <= 1'b0; done_irq_o <= 1'b0; err_irq_o <= 1'b0;
      ovr_o <= 1'b0; par_o <= 1'b0; frm_o <= 1'b0;
    end else begin
      done_irq_o <= done_i & ~(err_now & err_route_i);
      err_irq_o  <= done_i & err_now & err_route_i;
      if (done_i && !full_o) begin
        data_o <= frame_i.data;
        full_o <= 1'b1;
      end else if (buf_rd_i) begin
        full_o <= 1'b0;
      end
      // set wins over clear
      ovr_o <= ovr_now | (ovr_o & ~stat_rd_i);
      par_o <= (done_i & frame_i.par_err) | (par_o & ~stat_rd_i);
      frm_o <= (done_i & frame_i.frm_err) | (frm_o & ~stat_rd_i);
    end
  end
endmodule

// File: rtl/uart_rx_route.sv
module uart_rx_route
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unit_en_i,
  input  logic              rx_en_i,
  input  logic              baud_tick_i,
  input  logic              rx_i,
  input  logic              data7_i,
  input  logic [1:0]        parity_i,
  input  logic              err_route_i,
  input  logic              buf_rd_i,
  input  logic              stat_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              done_irq_o,
  output logic              err_irq_o,
  output logic              ovr_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  logic      line, fall, done;
  rx_frame_t frame;

  rx_sync_fall #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .rx_i, .line_o(line), .fall_o(fall)
  );

  rx_frame #(.OSR(OSR)) i_frame (
    .clk_i, .rst_ni,
    .active_i  (unit_en_i & rx_en_i),
    .tick_i    (baud_tick_i),
    .line_i    (line),
    .fall_i    (fall),
    .seven_i   (data7_i),
    .par_mode_i(par_mode_e'(parity_i)),
    .done_o    (done),
    .frame_o   (frame)
  );

  rx_buffer i_buf (
    .clk_i, .rst_ni,
    .done_i     (done),
    .frame_i    (frame),
    .err_route_i,
    .buf_rd_i,
    .stat_rd_i,
    .data_o     (rx_data_o),
    .full_o     (buf_full_o),
    .done_irq_o,
    .err_irq_o,
    .ovr_o,
    .par_o      (par_err_o),
    .frm_o      (frm_err_o)
  );
endmodule

// File: rtl/uart_rx_route_chk.sv
module uart_rx_route_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       unit_en_i,
  input logic       rx_en_i,
  input logic       buf_rd_i,
  input logic       stat_rd_i,
  input logic [7:0] rx_data_o,
  input logic       buf_full_o,
  input logic       done_irq_o,
  input logic       err_irq_o,
  input logic       ovr_o,
  input logic       par_err_o,
  input logic       frm_err_o
);
  a_r8_one_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_irq_o && err_irq_o));

  a_r5_full_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_irq_o || err_irq_o) |-> buf_full_o);

  a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unit_en_i && rx_en_i) |=> !(done_irq_o || err_irq_o));

  a_r2_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unit_en_i && rx_en_i) |=> $stable(rx_data_o));

  a_r9_ovr_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $stable(rx_data_o));

  a_r11_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !stat_rd_i) |=> ovr_o);

  a_r11_par_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !stat_rd_i) |=> par_err_o);

  a_r11_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_err_o && !stat_rd_i) |=> frm_err_o);
endmodule

bind uart_rx_route uart_rx_route_chk i_chk (.*);

// File: tb/test_uart_rx_route.sv
module test_uart_rx_route;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       unit_en = 1'b1, rx_en = 1'b1, tick = 1'b1, rx = 1'b1;
  logic       data7 = 1'b0, route = 1'b0, buf_rd = 1'b0, stat_rd = 1'b0;
  logic [1:0] parity = 2'b00;
  logic [7:0] rx_data;
  logic       buf_full, done_irq, err_irq, ovr, par_err, frm_err;
  int         n_chk = 0, n_fail = 0, n_done = 0, n_err = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  uart_rx_route i_uart_rx_route (
    .clk_i(clk), .rst_ni(rst_n), .unit_en_i(unit_en), .rx_en_i(rx_en),
    .baud_tick_i(tick), .rx_i(rx), .data7_i(data7), .parity_i(parity),
    .err_route_i(route), .buf_rd_i(buf_rd), .stat_rd_i(stat_rd),
    .rx_data_o(rx_data), .buf_full_o(buf_full), .done_irq_o(done_irq),
    .err_irq_o(err_irq), .ovr_o(ovr), .par_err_o(par_err), .frm_err_o(frm_err)
  );

  always @(negedge clk) begin
    if (done_irq) n_done++;
    if (err_irq)  n_err++;
  end

  // {exp_frm, exp_par, exp_data, bad_stop, bad_par, route, parity, data7, data}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'hA5},
    {1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 8'h3C},
    {1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 8'h3C},
    {1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 8'h81},
    {1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 8'hD5},
    {1'b0, 1'b1, 8'h7F, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 8'h7F},
    {1'b1, 1'b0, 8'hF0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 8'hF0},
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 8'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_time(logic b);
    rx = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(logic [7:0] d, logic seven, logic [1:0] pm,
                            logic bad_par, logic bad_stop);
    logic p;
    p = 1'b0;
    bit_time(1'b0);
    for (int i = 0; i < (seven ? 7 : 8); i++) begin
      p ^= d[i];
      bit_time(d[i]);
    end
    if (pm == 2'b01) bit_time(p ^ bad_par);
    if (pm == 2'b10) bit_time(~p ^ bad_par);
    bit_time(~bad_stop);
    rx = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_all();
    buf_rd = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0; stat_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", rx_data, 0);
    check("R1 flags", {buf_full, ovr, par_err, frm_err, done_irq, err_irq}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R5 R6 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [23:0] t;
      logic        exp_e;
      t = VEC[v];
      clear_all();
      data7 = t[8]; parity = t[10:9]; route = t[11];
      d0 = n_done; e0 = n_err;
      send_frame(t[7:0], t[8], t[10:9], t[12], t[13]);
      exp_e = t[22] | t[23];
      check("R4 data", rx_data, t[21:14]);
      check("R6 parity flag", par_err, t[22]);
      check("R7 framing flag", frm_err, t[23]);
      check("R8 done irq", n_done - d0, (exp_e && t[11]) ? 0 : 1);
      check("R8 err irq", n_err - e0, (exp_e && t[11]) ? 1 : 0);
      check("R5 full", buf_full, 1);
    end

    // R9 overrun, both routes
    clear_all();
    data7 = 1'b0; parity = 2'b00; route = 1'b1;
    send_frame(8'hA5, 1'b0, 2'b00, 1'b0, 1'b0);
    d0 = n_done; e0 = n_err;
    send_frame(8'h5A, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R9 data kept", rx_data, 8'hA5);
    check("R9 ovr flag", ovr, 1);
    check("R8 ovr err irq", n_err - e0, 1);
    check("R8 ovr no done", n_done - d0, 0);
    route = 1'b0;
    d0 = n_done;
    send_frame(8'h33, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R9 data kept route0", rx_data, 8'hA5);
    check("R8 ovr done irq", n_done - d0, 1);

    // R11 sticky flags and clears
    repeat (30) @(negedge clk);
    check("R11 ovr sticky", ovr, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    check("R11 flags cleared", {ovr, par_err, frm_err}, 0);
    check("R11 full kept", buf_full, 1);
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
    check("R11 full cleared", buf_full, 0);

    // R3 short glitch rejected
    d0 = n_done; e0 = n_err;
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    check("R3 no irq", (n_done - d0) + (n_err - e0), 0);
    check("R3 buffer empty", buf_full, 0);

    // R2 disabled
    unit_en = 1'b0;
    d0 = n_done; e0 = n_err;
    send_frame(8'hC3, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R2 unit off irq", (n_done - d0) + (n_err - e0), 0);
    check("R2 unit off data", rx_data, 8'hA5);
    unit_en = 1'b1; rx_en = 1'b0;
    send_frame(8'hC3, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R2 rx off irq", (n_done - d0) + (n_err - e0), 0);
    check("R2 rx off data", rx_data, 8'hA5);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);

    // R10 abort mid-frame
    clear_all();
    parity = 2'b01; route = 1'b0;
    send_frame(8'h12, 1'b0, 2'b01, 1'b1, 1'b0);
    buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
    d0 = n_done; e0 = n_err;
    bit_time(1'b0); bit_time(1'b1); bit_time(1'b0); bit_time(1'b1);
    rx_en = 1'b0;
    repeat (8) @(negedge clk);
    rx = 1'b1;
    repeat (200) @(negedge clk);
    rx_en = 1'b1;
    repeat (20) @(negedge clk);
    check("R10 no irq", (n_done - d0) + (n_err - e0), 0);
    check("R10 data kept", rx_data, 8'h12);
    check("R10 flags kept", {buf_full, ovr, par_err, frm_err}, 4'b0010);
    parity = 2'b00;
    send_frame(8'h99, 1'b0, 2'b00, 1'b0, 1'b0);
    check("R10 recovery data", rx_data, 8'h99);
    check("R5 recovery irq", n_done - d0, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule